// File: doc/BRIEF.md
# Sector Signature Compare Controller

This block builds a running 64-bit signature from data words that a DMA engine writes into it, one sector at a time. A sector is a programmed number of words. At the end of each sector the block latches the signature and compares it with an expected value. That expected value comes through a separate register, which a second DMA channel loads on the block's own request. A mismatch raises a sticky fail flag. A sector that ends before any expected value has arrived raises an overrun flag. An optional watchdog flags a sector that takes too long.

Software programs the word count per sector, the number of sectors per pass, and the timeout. It then enables auto mode. At that moment, and again after every sector, the block sends a one-cycle request for the next expected value. When the last sector of a pass completes, a pass-done flag is set and the counters start over. The next data write then begins a new pass.

All access goes through one write port with a 3-bit word address. Status is visible on a port and is cleared by writing ones to it.

Top module: `sig_cmp_ctrl`

## Requirements
- R1: After reset, `status_o`, `sig_o`, `sector_sig_o`, `dma_req_o` and all interrupt outputs are zero, and auto mode is off.
- R2: While auto mode is on, a write to address 0 compresses the data into the signature: next = (sig << 1) ^ data ^ (sig[63] ? 64'h1B : 0). While auto mode is off, a write to address 0 leaves `sig_o` unchanged.
- R3: A sector is complete on the data write that brings the word count to the pattern count written at address 2 (a count of 0 acts as 1). On that write, `sector_sig_o` takes the final signature and `sig_o` returns to zero.
- R4: At sector completion, if an expected value has been written to address 1 since the sector started and it differs from the final signature, status bit 0 (fail) is set. A matching value leaves that bit clear.
- R5: A write to address 5 that changes control bit 0 (auto) from 0 to 1 gives a one-cycle `dma_req_o` in the next cycle. The same write clears the signature, the word and sector counters, and the record of an expected value.
- R6: Every sector completion gives a one-cycle `dma_req_o` in the next cycle.
- R7: At sector completion with no expected value written since the sector started, status bit 2 (overrun) is set and no fail is evaluated.
- R8: A nonzero timeout N at address 4 is loaded at each sector start. If the sector has not completed N cycles later, status bit 1 (timeout) is set. A timeout of 0 never sets it.
- R9: Completion of the last sector of a pass (sector count at address 3, 0 acts as 1) sets status bit 3 (pass done) and rewinds the sector counter.
- R10: Status bits are sticky. A write to address 6 clears each bit whose data bit is 1. A set in the same cycle wins.
- R11: `irq_fail_o`, `irq_timeout_o` and `irq_overrun_o` equal status bits 0, 1 and 2, each gated by control bits 1, 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 64 | Write data |
| dma_req_o | output | 1 | One-cycle request for the next expected value |
| irq_fail_o | output | 1 | Fail interrupt |
| irq_timeout_o | output | 1 | Timeout interrupt |
| irq_overrun_o | output | 1 | Overrun interrupt |
| status_o | output | 4 | Sticky flags: pass done, overrun, timeout, fail (bit 3 to 0) |
| sig_o | output | 64 | Running signature |
| sector_sig_o | output | 64 | Signature latched at the last sector end |

## Verification
Assertions run on every cycle and check the following:
- each request follows a data or control write;
- the signature holds still when neither kind of write occurred;
- a new fail, overrun or pass-done flag coincides with a request;
- a new timeout never does;
- a status bit falls only under a matching write-one-to-clear.

Three things are shown only by the bench's scenarios, where the reference model computes exact signatures:
- whether a compare actually matches or mismatches;
- the count at which a sector ends;
- that the timeout fires after exactly N cycles, or never when N is zero.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_EXP  = 3'd1;
  localparam logic [AW-1:0] A_PAT  = 3'd2;
  localparam logic [AW-1:0] A_SEC  = 3'd3;
  localparam logic [AW-1:0] A_TMO  = 3'd4;
  localparam logic [AW-1:0] A_CTRL = 3'd5;
  localparam logic [AW-1:0] A_STAT = 3'd6;

  localparam int unsigned NST = 4;
  typedef enum int unsigned {ST_FAIL = 0, ST_TMO = 1, ST_OVR = 2, ST_PASS = 3} st_bit_e;
  typedef enum int unsigned {C_AUTO = 0, C_FAIL_IE = 1, C_TMO_IE = 2, C_OVR_IE = 3} ctl_bit_e;
endpackage

// File: rtl/scc_misr.sv
module scc_misr #(
  parameter int unsigned      DW   = 64,
  parameter logic [DW-1:0]    POLY = 64'h1B
) (
  input  logic [DW-1:0] sig_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] next_o
);
  assign next_o[0] = data_i[0] ^ (sig_i[DW-1] & POLY[0]);
  for (genvar i = 1; i < DW; i++) begin : g_bit
    assign next_o[i] = sig_i[i-1] ^ data_i[i] ^ (sig_i[DW-1] & POLY[i]);
  end
endmodule

// File: rtl/scc_seq.sv
module scc_seq #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rewind_i,
  input  logic          step_i,
  input  logic [CW-1:0] pat_lim_i,
  input  logic [CW-1:0] sec_lim_i,
  output logic          sec_end_o,
  output logic          pass_end_o
);
  logic [CW-1:0] wcnt_q, scnt_q;
  logic [CW:0]   pat_eff, sec_eff, wnext, snext;

  assign pat_eff    = (pat_lim_i == '0) ? (CW+1)'(1) : {1'b0, pat_lim_i};
  assign sec_eff    = (sec_lim_i == '0) ? (CW+1)'(1) : {1'b0, sec_lim_i};
  assign wnext      = {1'b0, wcnt_q} + (CW+1)'(1);
  assign snext      = {1'b0, scnt_q} + (CW+1)'(1);
  assign sec_end_o  = step_i && (wnext >= pat_eff);
  assign pass_end_o = sec_end_o && (snext >= sec_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      scnt_q <= '0;
    end else if (rewind_i) begin
      wcnt_q <= '0;
      scnt_q <= '0;
    end else if (sec_end_o) begin
      wcnt_q <= '0;
      scnt_q <= pass_end_o ? '0 : snext[CW-1:0];
    end else if (step_i) begin
      wcnt_q <= wnext[CW-1:0];
    end
  end
endmodule

// File: rtl/scc_timer.sv
module scc_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic          act_q;

  assign expire_o = run_i && act_q && !load_i && (cnt_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      act_q <= (load_val_i != '0);
    end else if (run_i && act_q) begin
      cnt_q <= cnt_q - TW'(1);
      if (cnt_q == TW'(1)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_cmp_ctrl.sv
module sig_cmp_ctrl
  import scc_pkg::*;
#(
  parameter int unsigned   DW   = 64,
  parameter int unsigned   CW   = 16,
  parameter int unsigned   TW   = 16,
  parameter logic [DW-1:0] POLY = 64'h1B
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           dma_req_o,
  output logic           irq_fail_o,
  output logic           irq_timeout_o,
  output logic           irq_overrun_o,
  output logic [NST-1:0] status_o,
  output logic [DW-1:0]  sig_o,
  output logic [DW-1:0]  sector_sig_o
);
  logic [3:0]     ctrl_q;
  logic [CW-1:0]  pat_q, sec_q;
  logic [TW-1:0]  tmo_q;
  logic [DW-1:0]  exp_q, sig_q, ssig_q, sig_next;
  logic           fresh_q, dma_q;
  logic [NST-1:0] st_q, st_set, st_clr;
  logic           auto, entry, step, sec_end, pass_end, expire;

  assign auto  = ctrl_q[C_AUTO];
  assign entry = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[C_AUTO] && !auto;
  assign step  = wr_en_i && (wr_addr_i == A_DATA) && auto;

  scc_misr #(.DW(DW), .POLY(POLY)) u_misr (
    .sig_i (sig_q),
    .data_i(wr_data_i),
    .next_o(sig_next)
  );

  scc_seq #(.CW(CW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rewind_i  (entry),
    .step_i    (step),
    .pat_lim_i (pat_q),
    .sec_lim_i (sec_q),
    .sec_end_o (sec_end),
    .pass_end_o(pass_end)
  );

  scc_timer #(.TW(TW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (auto),
    .load_i    (entry || sec_end),
    .load_val_i(tmo_q),
    .expire_o  (expire)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_FAIL] = sec_end && fresh_q && (sig_next != exp_q);
    st_set[ST_OVR]  = sec_end && !fresh_q;
    st_set[ST_TMO]  = expire;
    st_set[ST_PASS] = pass_end;
    st_clr          = (wr_en_i && (wr_addr_i == A_STAT)) ? wr_data_i[NST-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pat_q   <= '0;
      sec_q   <= '0;
      tmo_q   <= '0;
      exp_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        unique case (wr_addr_i)
          A_PAT:   pat_q  <= wr_data_i[CW-1:0];
          A_SEC:   sec_q  <= wr_data_i[CW-1:0];
          A_TMO:   tmo_q  <= wr_data_i[TW-1:0];
          A_CTRL:  ctrl_q <= wr_data_i[3:0];
          A_EXP:   exp_q  <= wr_data_i;
          default: ;
        endcase
      end
      if (wr_en_i && (wr_addr_i == A_EXP)) fresh_q <= 1'b1;
      else if (entry || sec_end)           fresh_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q  <= '0;
      ssig_q <= '0;
      st_q   <= '0;
      dma_q  <= 1'b0;
    end else begin
      dma_q <= entry || sec_end;
      st_q  <= (st_q & ~st_clr) | st_set;
      if (sec_end) ssig_q <= sig_next;
      if (entry || sec_end) sig_q <= '0;
      else if (step)        sig_q <= sig_next;
    end
  end

  assign dma_req_o     = dma_q;
  assign status_o      = st_q;
  assign sig_o         = sig_q;
  assign sector_sig_o  = ssig_q;
  assign irq_fail_o    = st_q[ST_FAIL] && ctrl_q[C_FAIL_IE];
  assign irq_timeout_o = st_q[ST_TMO]  && ctrl_q[C_TMO_IE];
  assign irq_overrun_o = st_q[ST_OVR]  && ctrl_q[C_OVR_IE];
endmodule

// File: rtl/scc_chk.sv
module scc_chk
  import scc_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [AW-1:0]  wr_addr_i,
  input logic [DW-1:0]  wr_data_i,
  input logic           dma_req_o,
  input logic [NST-1:0] status_o,
  input logic [DW-1:0]  sig_o
);
  assert_dma_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(wr_en_i && (wr_addr_i == A_DATA || wr_addr_i == A_CTRL)));

  assert_sig_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && (wr_addr_i == A_DATA || wr_addr_i == A_CTRL)) |-> $stable(sig_o));

  assert_sector_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && $past(wr_addr_i == A_DATA)) |-> (sig_o == '0));

  assert_fail_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_FAIL]) |-> dma_req_o);

  assert_overrun_no_fail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_OVR]) |-> (dma_req_o && !$rose(status_o[ST_FAIL])));

  assert_timeout_mid_sector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_TMO]) |-> !dma_req_o);

  assert_pass_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_PASS]) |-> (dma_req_o && sig_o == '0));

  for (genvar k = 0; k < NST; k++) begin : g_sticky
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[k]) |-> $past(wr_en_i && wr_addr_i == A_STAT && wr_data_i[k]));
  end
endmodule

bind sig_cmp_ctrl scc_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .dma_req_o(dma_req_o),
  .status_o (status_o),
  .sig_o    (sig_o)
);

// File: tb/tb_sig_cmp_ctrl.sv
module tb_sig_cmp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] POLY = 64'h1B;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic dma_req, irq_fail, irq_tmo, irq_ovr;
  logic [3:0] status;
  logic [63:0] sig, ssig;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_cmp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dma_req_o(dma_req), .irq_fail_o(irq_fail), .irq_timeout_o(irq_tmo), .irq_overrun_o(irq_ovr),
    .status_o(status), .sig_o(sig), .sector_sig_o(ssig)
  );

  function automatic logic [63:0] mf(input logic [63:0] s, input logic [63:0] d);
    return (s << 1) ^ d ^ (s[63] ? POLY : 64'h0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_sig, m_ssig, m_exp;
  logic [3:0]  m_st, m_ctrl;
  bit          m_dma, m_fresh, m_tact;
  int          m_w, m_s, m_pat, m_sec, m_tmo, m_tcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sig = 0; m_ssig = 0; m_exp = 0; m_st = 0; m_ctrl = 0; m_dma = 0;
      m_fresh = 0; m_tact = 0; m_w = 0; m_s = 0; m_pat = 0; m_sec = 0; m_tmo = 0; m_tcnt = 0;
    end else begin
      bit entry, send;
      logic [3:0] set, clr;
      logic [63:0] nsig;
      entry = wr_en && wr_addr == 5 && wr_data[0] && !m_ctrl[0];
      send = 0; set = 0; clr = 0; nsig = m_sig;
      if (wr_en && wr_addr == 0 && m_ctrl[0]) begin
        nsig = mf(m_sig, wr_data);
        if (m_w + 1 >= (m_pat == 0 ? 1 : m_pat)) send = 1;
      end
      if (m_ctrl[0] && m_tact && !send && !entry) begin
        if (m_tcnt == 1) begin set[1] = 1; m_tact = 0; end
        m_tcnt = m_tcnt - 1;
      end
      if (wr_en && wr_addr == 6) clr = wr_data[3:0];
      if (send) begin
        m_ssig = nsig;
        if (!m_fresh) set[2] = 1;
        else if (nsig != m_exp) set[0] = 1;
        nsig = 0; m_w = 0; m_fresh = 0;
        if (m_s + 1 >= (m_sec == 0 ? 1 : m_sec)) begin set[3] = 1; m_s = 0; end
        else m_s++;
      end else if (wr_en && wr_addr == 0 && m_ctrl[0]) m_w++;
      if (entry) begin nsig = 0; m_w = 0; m_s = 0; m_fresh = 0; end
      if (entry || send) begin m_tcnt = m_tmo; m_tact = (m_tmo != 0); end
      m_sig = nsig;
      m_dma = entry || send;
      m_st = (m_st & ~clr) | set;
      if (wr_en) begin
        case (wr_addr)
          1: begin m_exp = wr_data; m_fresh = 1; end
          2: m_pat = int'(wr_data[15:0]);
          3: m_sec = int'(wr_data[15:0]);
          4: m_tmo = int'(wr_data[15:0]);
          5: m_ctrl = wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sig === m_sig, "R2 sig_o", sig, m_sig);
      chk(ssig === m_ssig, "R3 sector_sig_o", ssig, m_ssig);
      chk(dma_req === m_dma, "R5/R6 dma_req_o", 64'(dma_req), 64'(m_dma));
      chk(status === m_st, "R10 status_o", 64'(status), 64'(m_st));
      chk(irq_fail === (m_st[0] & m_ctrl[1]), "R11 irq_fail_o", 64'(irq_fail), 64'(m_st[0] & m_ctrl[1]));
      chk(irq_tmo === (m_st[1] & m_ctrl[2]), "R11 irq_timeout_o", 64'(irq_tmo), 64'(m_st[1] & m_ctrl[2]));
      chk(irq_ovr === (m_st[2] & m_ctrl[3]), "R11 irq_overrun_o", 64'(irq_ovr), 64'(m_st[2] & m_ctrl[3]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr_en = 0; wr_addr = 0; wr_data = 0; end
  endtask

  initial begin
    logic [63:0] e, held;
    logic [63:0] words [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 0 && sig == 0 && ssig == 0 && !dma_req && !irq_fail && !irq_tmo && !irq_ovr,
        "R1 reset state", {status, sig[59:0]}, 64'h0);

    // pattern 4, sector 2, all interrupts enabled
    wr(2, 4); wr(3, 2); wr(5, 'hF); idle(1);
    chk(dma_req == 1, "R5 request on auto entry", 64'(dma_req), 1);
    idle(1);
    chk(dma_req == 0, "R5 request lasts one cycle", 64'(dma_req), 0);

    words[0] = 64'h0123_4567_89AB_CDEF; words[1] = 64'hFFFF_0000_FFFF_0000;
    words[2] = 64'h8000_0000_0000_0001; words[3] = 64'hDEAD_BEEF_0000_1111;
    e = 0;
    foreach (words[i]) e = mf(e, words[i]);
    wr(1, e);
    foreach (words[i]) wr(0, words[i]);
    idle(1);
    chk(ssig == e, "R3 sector signature latched", ssig, e);
    chk(sig == 0, "R3 signature cleared at sector end", sig, 0);
    chk(status[0] == 0, "R4 matching expected no fail", 64'(status), 0);
    chk(dma_req == 1, "R6 request after sector", 64'(dma_req), 1);

    // second sector with wrong expected: fail and pass done
    wr(1, ~e);
    foreach (words[i]) wr(0, words[i] ^ 64'(i));
    idle(1);
    chk(status[0] == 1, "R4 mismatch sets fail", 64'(status), 1);
    chk(status[3] == 1, "R9 pass done after two sectors", 64'(status), 8);
    chk(irq_fail == 1, "R11 fail irq enabled", 64'(irq_fail), 1);
    wr(5, 'hD); idle(1);
    chk(irq_fail == 0 && status[0] == 1, "R11 fail irq gated off", 64'(irq_fail), 0);
    wr(6, 'hF); idle(1);
    chk(status == 0, "R10 write-one-to-clear", 64'(status), 0);

    // overrun: no expected value
    foreach (words[i]) wr(0, words[i]);
    idle(1);
    chk(status[2] == 1 && status[0] == 0, "R7 overrun without fail", 64'(status), 4);

    // writes ignored while auto is off
    wr(0, 64'h55); wr(0, 64'hAA); idle(1);
    held = sig;
    wr(5, 0); wr(0, 64'h1234); idle(1);
    chk(sig == held, "R2 data ignored with auto off", sig, held);

    // timeout of 5 cycles
    wr(6, 'hF); wr(4, 5); wr(5, 'hF); idle(4);
    chk(status[1] == 0, "R8 no timeout before N cycles", 64'(status), 0);
    idle(2);
    chk(status[1] == 1 && irq_tmo == 1, "R8 timeout after N cycles", 64'(status), 2);

    // timeout zero disables
    wr(6, 'hF); wr(5, 0); wr(4, 0); wr(5, 'hF); idle(30);
    chk(status[1] == 0, "R8 zero timeout never fires", 64'(status), 0);

    // pattern and sector count of zero act as one
    wr(2, 0); wr(3, 0);
    e = mf(64'h0, 64'hCAFE_F00D_1234_5678);
    wr(1, e); wr(0, 64'hCAFE_F00D_1234_5678); idle(1);
    chk(ssig == e && status[0] == 0, "R3 zero pattern count is one word", ssig, e);
    chk(status[3] == 1 && dma_req == 1, "R9 zero sector count is one sector", 64'(status), 8);

    // mixed traffic checked by the model every cycle
    wr(2, 3); wr(3, 3); wr(4, 7);
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r < 9)       wr(0, {$urandom, $urandom});
      else if (r < 12) wr(1, {$urandom, $urandom});
      else if (r < 13) wr(6, 64'($urandom % 16));
      else if (r < 14) wr(5, 64'($urandom % 16));
      else if (r < 15) wr(2, 64'($urandom % 5));
      else             idle(1);
    end
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule